// File: doc/BRIEF.md
# Exception Context Save and Vector Unit

This block keeps a processor's privileged control state and sequences it across exception entry and handler return. When the entry strobe is seen, it captures the live status word, the address of the instruction the event hit, and the stack-pointer general register (R15) into three shadow registers. In the next cycle it issues a redirect to the handler address. That address is normally the vector base plus a cause-dependent offset. When user-break debugging is enabled and the event is a user break, the address is the debug base register itself. A return strobe redirects fetch back to the saved PC and hands the saved status back for reloading.

Software reaches the five registers through a small register port. Reads are combinational. Writes take effect at the clock edge. Any access outside privileged mode is refused. The redirect, restore and illegal-access outputs are single-cycle control pulses with no back-pressure: the pipeline must accept a redirect in the cycle it is shown. The current-PC output holds the last redirect target, and starts from the reset fetch address.

Top module: `exc_ctx_unit`

## Requirements
- R1: One cycle after `exc_take` is high at a clock edge, the saved-status register (port address 0) holds the `status_in` value sampled at that edge.
- R2: On the same entry edge, the saved-PC register (address 1) takes `fault_pc`.
- R3: On the same entry edge, the saved-R15 register (address 2) takes `r15_in`.
- R4: In the cycle after an entry, `redirect_valid` is 1 for exactly one cycle. In that cycle `redirect_pc` is the vector base (address 3) plus the zero-extended `cause_off`, using the base value held before the edge. `cur_pc` takes the same value.
- R5: When `dbg_en` and `ubreak` are both 1 at entry, the handler target is the debug base register (address 4) with no offset added. If either is 0, the target follows R4.
- R6: In the cycle after `ret_take`, `redirect_valid` is 1 with `redirect_pc` equal to the saved PC, and `sr_load` is 1 with `sr_restore` equal to the saved status. If `exc_take` is high on the same edge, the entry is taken and the return is dropped (`sr_load` stays 0).
- R7: While and after reset, the vector base reads 0x00000000, `cur_pc` is 0xA0000000, and `redirect_valid`, `sr_load` and `illegal` are 0.
- R8: With `priv`=1, `rp_rdata` shows the register at `rp_addr` (0 saved status, 1 saved PC, 2 saved R15, 3 vector base, 4 debug base) in the same cycle. Addresses 5 to 7 read 0. With `priv`=0 the read is 0.
- R9: A write (`rp_we`=1) with `priv`=0 changes no register, and `illegal` is 1 in the following cycle only. A privileged write to addresses 5 to 7 is dropped without raising `illegal`.
- R10: If an entry and a privileged write to addresses 0 to 2 fall on the same edge, the register holds the entry value. Writes to addresses 3 and 4 on that edge still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_in | input | 32 | Live status word |
| fault_pc | input | 32 | Address of the instruction the event hit |
| r15_in | input | 32 | Current R15 value |
| exc_take | input | 1 | Exception or interrupt entry strobe |
| cause_off | input | 12 | Cause-dependent offset added to the vector base |
| ubreak | input | 1 | Marks the entry as a user-break event |
| dbg_en | input | 1 | User-break debugging enable |
| ret_take | input | 1 | Handler return strobe |
| priv | input | 1 | Privileged-mode indication |
| rp_we | input | 1 | Register port write strobe |
| rp_addr | input | 3 | Register port address |
| rp_wdata | input | 32 | Register port write data |
| rp_rdata | output | 32 | Register port read data |
| illegal | output | 1 | Refused write, one-cycle pulse |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Redirect target |
| sr_load | output | 1 | Status restore strobe |
| sr_restore | output | 32 | Status value to restore |
| cur_pc | output | 32 | Current fetch address |

## Verification
A capture register loaded from the wrong source, or missing an entry, shows on the next return: the `redirect_pc` or `sr_restore` emitted is wrong. It also shows on the register port in the first cycle after the entry. A corrupted base register or a wrong base selection shows as a wrong `redirect_pc` in the cycle right after the entry that uses it. A lost privilege check shows as a changed readback and a missing `illegal` pulse one cycle after the write. Because the bench runs entries and returns back to back, most state faults reach the outputs within a few cycles.

// File: rtl/exc_ctx_pkg.sv
package exc_ctx_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NUM_SAVE = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_SSR = 3'd0,
    RA_SPC = 3'd1,
    RA_SGR = 3'd2,
    RA_VBR = 3'd3,
    RA_DBR = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_ENTRY = 2'd1,
    RD_RET   = 2'd2
  } redir_kind_e;
endpackage

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
  import exc_ctx_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] VBR_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_take,
  input  logic [XLEN-1:0]   status_in,
  input  logic [XLEN-1:0]   fault_pc,
  input  logic [XLEN-1:0]   r15_in,
  input  logic              priv,
  input  logic              rp_we,
  input  logic [ADDR_W-1:0] rp_addr,
  input  logic [XLEN-1:0]   rp_wdata,
  output logic [XLEN-1:0]   rp_rdata,
  output logic              illegal,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   sgr,
  output logic [XLEN-1:0]   vbr,
  output logic [XLEN-1:0]   dbr
);
  logic [XLEN-1:0] save_q   [NUM_SAVE];
  logic [XLEN-1:0] save_src [NUM_SAVE];
  logic            wr_ok;

  assign wr_ok       = rp_we && priv;
  assign save_src[0] = status_in;
  assign save_src[1] = fault_pc;
  assign save_src[2] = r15_in;

  // Shadow registers have no defined reset value, so they carry no reset.
  for (genvar i = 0; i < NUM_SAVE; i++) begin : g_save
    always_ff @(posedge clk) begin
      if (exc_take) begin
        save_q[i] <= save_src[i];
      end else if (wr_ok && (rp_addr == ADDR_W'(i))) begin
        save_q[i] <= rp_wdata;
      end
    end
  end

  assign ssr = save_q[0];
  assign spc = save_q[1];
  assign sgr = save_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbr <= VBR_RST;
    end else if (wr_ok && rp_addr == RA_VBR) begin
      vbr <= rp_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && rp_addr == RA_DBR) begin
      dbr <= rp_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal <= 1'b0;
    end else begin
      illegal <= rp_we && !priv;
    end
  end

  always_comb begin
    rp_rdata = '0;
    if (priv) begin
      case (rp_addr)
        RA_SSR:  rp_rdata = ssr;
        RA_SPC:  rp_rdata = spc;
        RA_SGR:  rp_rdata = sgr;
        RA_VBR:  rp_rdata = vbr;
        RA_DBR:  rp_rdata = dbr;
        default: rp_rdata = '0;
      endcase
    end
  end

  AST_SSR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> ssr == $past(status_in)); // R1
  AST_SPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> spc == $past(fault_pc)); // R2
  AST_SGR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> sgr == $past(r15_in)); // R3
  AST_USER_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_we && !priv && !exc_take) |=> ($stable(vbr) && $stable(ssr) && illegal)); // R9
  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rp_we && !priv) |=> !illegal); // R9
  AST_ENTRY_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && rp_we && priv && rp_addr == RA_SPC) |=> spc == $past(fault_pc)); // R10
endmodule

// File: rtl/exc_ctx_vector.sv
module exc_ctx_vector #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic [XLEN-1:0]  vbr,
  input  logic [XLEN-1:0]  dbr,
  input  logic [OFF_W-1:0] cause_off,
  input  logic             dbg_en,
  input  logic             ubreak,
  output logic [XLEN-1:0]  handler
);
  localparam int unsigned PAD_W = XLEN - OFF_W;

  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] vec_target;
  logic            use_dbg;

  assign off_ext    = {{PAD_W{1'b0}}, cause_off};
  assign vec_target = vbr + off_ext;
  assign use_dbg    = dbg_en && ubreak;
  assign handler    = use_dbg ? dbr : vec_target;
endmodule

// File: rtl/exc_ctx_seq.sv
module exc_ctx_seq
  import exc_ctx_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] PC_RST = 32'hA000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_take,
  input  logic            ret_take,
  input  logic [XLEN-1:0] handler,
  input  logic [XLEN-1:0] spc,
  input  logic [XLEN-1:0] ssr,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            sr_load,
  output logic [XLEN-1:0] sr_restore,
  output logic [XLEN-1:0] cur_pc
);
  redir_kind_e     kind;
  logic [XLEN-1:0] target;

  always_comb begin
    if (exc_take) begin
      kind   = RD_ENTRY;
      target = handler;
    end else if (ret_take) begin
      kind   = RD_RET;
      target = spc;
    end else begin
      kind   = RD_NONE;
      target = cur_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= PC_RST;
      sr_load        <= 1'b0;
      sr_restore     <= '0;
      cur_pc         <= PC_RST;
    end else begin
      redirect_valid <= kind != RD_NONE;
      sr_load        <= kind == RD_RET;
      if (kind != RD_NONE) begin
        redirect_pc <= target;
        cur_pc      <= target;
      end
      if (kind == RD_RET) begin
        sr_restore <= ssr;
      end
    end
  end

  AST_ENTRY_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (redirect_valid && !sr_load && redirect_pc == $past(handler))); // R4
  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_take && !exc_take) |=> (redirect_valid && sr_load && redirect_pc == $past(spc)
                                 && sr_restore == $past(ssr))); // R6
  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_take || ret_take) |=> (!redirect_valid && $stable(cur_pc))); // R4
  AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> cur_pc == redirect_pc); // R4
endmodule

// File: rtl/exc_ctx_unit.sv
module exc_ctx_unit
  import exc_ctx_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 12,
  parameter logic [XLEN-1:0] VBR_RST = '0,
  parameter logic [XLEN-1:0] PC_RST  = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   status_in,
  input  logic [XLEN-1:0]   fault_pc,
  input  logic [XLEN-1:0]   r15_in,
  input  logic              exc_take,
  input  logic [OFF_W-1:0]  cause_off,
  input  logic              ubreak,
  input  logic              dbg_en,
  input  logic              ret_take,
  input  logic              priv,
  input  logic              rp_we,
  input  logic [ADDR_W-1:0] rp_addr,
  input  logic [XLEN-1:0]   rp_wdata,
  output logic [XLEN-1:0]   rp_rdata,
  output logic              illegal,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              sr_load,
  output logic [XLEN-1:0]   sr_restore,
  output logic [XLEN-1:0]   cur_pc
);
  logic [XLEN-1:0] ssr, spc, sgr, vbr, dbr, handler;

  exc_ctx_regs #(.XLEN(XLEN), .VBR_RST(VBR_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .exc_take(exc_take),
    .status_in(status_in), .fault_pc(fault_pc), .r15_in(r15_in),
    .priv(priv), .rp_we(rp_we), .rp_addr(rp_addr), .rp_wdata(rp_wdata),
    .rp_rdata(rp_rdata), .illegal(illegal),
    .ssr(ssr), .spc(spc), .sgr(sgr), .vbr(vbr), .dbr(dbr)
  );

  exc_ctx_vector #(.XLEN(XLEN), .OFF_W(OFF_W)) u_vec (
    .vbr(vbr), .dbr(dbr), .cause_off(cause_off),
    .dbg_en(dbg_en), .ubreak(ubreak), .handler(handler)
  );

  exc_ctx_seq #(.XLEN(XLEN), .PC_RST(PC_RST)) u_seq (
    .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .ret_take(ret_take),
    .handler(handler), .spc(spc), .ssr(ssr),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .sr_load(sr_load), .sr_restore(sr_restore), .cur_pc(cur_pc)
  );

  AST_DEBUG_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && dbg_en && ubreak) |=> redirect_pc == $past(dbr)); // R5
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (cur_pc == PC_RST && !redirect_valid && !sr_load && !illegal)); // R7
endmodule

// File: tb/exc_ctx_unit_tb.sv
module exc_ctx_unit_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] status_in, fault_pc, r15_in, rp_wdata;
  logic exc_take, ubreak, dbg_en, ret_take, priv, rp_we;
  logic [11:0] cause_off;
  logic [2:0] rp_addr;
  logic [31:0] rp_rdata, redirect_pc, sr_restore, cur_pc;
  logic illegal, redirect_valid, sr_load;

  always #2 clk = ~clk;

  exc_ctx_unit u_dut (
    .clk(clk), .rst_n(rst_n), .status_in(status_in), .fault_pc(fault_pc),
    .r15_in(r15_in), .exc_take(exc_take), .cause_off(cause_off), .ubreak(ubreak),
    .dbg_en(dbg_en), .ret_take(ret_take), .priv(priv), .rp_we(rp_we),
    .rp_addr(rp_addr), .rp_wdata(rp_wdata), .rp_rdata(rp_rdata), .illegal(illegal),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .sr_load(sr_load),
    .sr_restore(sr_restore), .cur_pc(cur_pc)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bench model; index 0 ssr,1 spc,2 sgr,3 vbr,4 dbr
  logic [31:0] m_reg [5];
  bit          m_known [5];
  logic [31:0] m_pc, m_rpc, m_srr;
  bit          m_rv, m_sl, m_ill;
  string       m_tag;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(logic p, logic [2:0] a);
    if (!p || a > 3'd4) return 32'h0;
    return m_reg[a];
  endfunction

  function automatic logic [31:0] exp_handler(logic de, logic ub, logic [11:0] off);
    if (de && ub) return m_reg[4];
    return m_reg[3] + {20'h0, off};
  endfunction

  task automatic idle_inputs();
    exc_take = 0; ret_take = 0; rp_we = 0; ubreak = 0; dbg_en = 0;
    priv = 1; rp_addr = 3'd3; rp_wdata = 0; cause_off = 0;
    status_in = 0; fault_pc = 0; r15_in = 0;
  endtask

  // inputs already driven after a negedge; check read, advance model, check outputs
  task automatic step();
    #1;
    if (!(priv && rp_addr <= 3'd4 && !m_known[rp_addr]))
      check("R8 rp_rdata", rp_rdata, exp_read(priv, rp_addr));
    m_ill = rp_we && !priv;
    m_sl = 0;
    if (exc_take) begin
      m_rv = 1; m_rpc = exp_handler(dbg_en, ubreak, cause_off);
      m_tag = (dbg_en && ubreak) ? "R5 redirect_pc" : "R4 redirect_pc";
    end else if (ret_take) begin
      m_rv = 1; m_sl = 1; m_rpc = m_reg[1]; m_srr = m_reg[0];
      m_tag = "R6 redirect_pc";
    end else begin
      m_rv = 0;
    end
    if (rp_we && priv && rp_addr <= 3'd4 && !(exc_take && rp_addr <= 3'd2)) begin
      m_reg[rp_addr] = rp_wdata; m_known[rp_addr] = 1;
    end
    if (exc_take) begin
      m_reg[0] = status_in; m_reg[1] = fault_pc; m_reg[2] = r15_in;
      m_known[0] = 1; m_known[1] = 1; m_known[2] = 1;
    end
    if (m_rv) m_pc = m_rpc;
    @(posedge clk); #1;
    check("R4 redirect_valid", {31'h0, redirect_valid}, {31'h0, m_rv});
    check("R6 sr_load", {31'h0, sr_load}, {31'h0, m_sl});
    check("R9 illegal", {31'h0, illegal}, {31'h0, m_ill});
    check("R4 cur_pc", cur_pc, m_pc);
    if (m_rv) check(m_tag, redirect_pc, m_rpc);
    if (m_sl) check("R6 sr_restore", sr_restore, m_srr);
    @(negedge clk);
  endtask

  task automatic port_write(logic p, logic [2:0] a, logic [31:0] d);
    idle_inputs(); priv = p; rp_we = 1; rp_addr = a; rp_wdata = d;
    step();
  endtask

  task automatic peek(logic [2:0] a, string tag);
    idle_inputs(); rp_addr = a; #1;
    check(tag, rp_rdata, exp_read(1'b1, a));
    step();
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1357));
    for (int i = 0; i < 5; i++) begin m_reg[i] = 0; m_known[i] = 0; end
    m_reg[3] = 0; m_known[3] = 1; m_pc = 32'hA000_0000;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 cur_pc reset", cur_pc, 32'hA000_0000);
    check("R7 vbr reset", rp_rdata, 32'h0);
    check("R7 flags reset", {29'h0, redirect_valid, sr_load, illegal}, 32'h0);
    rst_n = 1;
    step();
    // directed
    port_write(1, 3'd3, 32'h8000_1000);
    port_write(1, 3'd4, 32'h9000_0040);
    port_write(0, 3'd3, 32'hDEAD_BEEF);                  // R9 refused
    peek(3'd3, "R9 vbr unchanged");
    port_write(1, 3'd6, 32'h1234_5678);                  // R9 unmapped, no flag
    peek(3'd6, "R8 unmapped reads 0");
    idle_inputs(); priv = 0; rp_addr = 3'd3; step();     // R8 nonpriv read 0
    idle_inputs(); exc_take = 1; cause_off = 12'hFFF;
    status_in = 32'h4000_00F0; fault_pc = 32'h0C00_1234; r15_in = 32'h0FFF_FFF0;
    step();                                               // R4 max offset
    peek(3'd0, "R1 ssr capture");
    peek(3'd1, "R2 spc capture");
    peek(3'd2, "R3 sgr capture");
    idle_inputs(); exc_take = 1; dbg_en = 1; ubreak = 1; cause_off = 12'h100;
    fault_pc = 32'h0C00_2000; step();                     // R5 debug base
    idle_inputs(); exc_take = 1; dbg_en = 0; ubreak = 1; cause_off = 12'h100;
    step();                                               // R5 disabled -> vbr
    idle_inputs(); exc_take = 1; rp_we = 1; rp_addr = 3'd0; rp_wdata = 32'h1111_1111;
    status_in = 32'h2222_2222; step();                    // R10
    peek(3'd0, "R10 entry wins");
    idle_inputs(); exc_take = 1; rp_we = 1; rp_addr = 3'd3; rp_wdata = 32'h8800_0000;
    step();                                               // R10 base write still lands
    peek(3'd3, "R10 vbr write same edge");
    idle_inputs(); ret_take = 1; step();                  // R6 return
    idle_inputs(); exc_take = 1; ret_take = 1; fault_pc = 32'h0C00_3000; step(); // R6 entry wins
    idle_inputs(); ret_take = 1; step();
    // random
    for (int k = 0; k < 3000; k++) begin
      idle_inputs();
      exc_take  = ($urandom % 7) == 0;
      ret_take  = ($urandom % 8) == 0;
      dbg_en    = $urandom % 2;
      ubreak    = $urandom % 2;
      cause_off = 12'($urandom);
      status_in = $urandom; fault_pc = $urandom; r15_in = $urandom;
      priv      = ($urandom % 5) != 0;
      rp_we     = ($urandom % 4) == 0;
      rp_addr   = 3'($urandom);
      rp_wdata  = $urandom;
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule